// File: doc/BRIEF.md
# Four-Pin Port Function Multiplexer

This block sits between four physical port pins and two users: a small general-purpose port (a direction register and a data register), and the external-bus controller that produces strobes such as output enable, clock enable, chip selects, DRAM row strobes, the SDRAM clock and write enable. For every pin it decides which of them owns the pin. It then drives the pin's output value and output enable, and reports a function code. Bus timing is produced elsewhere, and the strobe values come in as inputs.

The owner of each pin follows a fixed priority. The inputs to that priority are the operating mode (single-chip or expanded), an expansion flag, a chip-select enable bit for each pin, two output-enable control bits, the memory type of areas 4 and 5, a flag for contiguous synchronous DRAM, and a DRAM-control input pin. Software reaches the port through a small synchronous register port. A write takes effect on the next clock edge.

Top module: `portx_pinmux`

## Requirements
- R1: While reset is asserted every `pin_oe_o` bit is 0. After reset both registers are zero, every pin reports function code 0 (port) and no pin is driven.
- R2: A write to address 0 loads bits 3:0 of the write data into the direction register on the next edge, and a read of address 0 always returns 0x00. A write to address 1 loads bits 3:0 into the data register, and address 1 reads back with bits 7:4 as zero.
- R3: A pin with function code 0 has its output enable equal to its direction bit and drives its data-register bit. A read of address 2 returns, per bit, the data-register bit for output pins and the `pin_in_i` level for input pins, with bits 7:4 zero.
- R4: When expanded and both `oe_en_i` and `oe_sel_i` are 1, pin 3 is driven whatever its direction bit. It drives `oe_strobe_i` with code 1, or `cke_strobe_i` with code 2 when `sdram_contig_i` is 1.
- R5: With pin 3 not taken by output enable, `cs_en_i[3]`=1 and direction bit 1, pin 3 drives `cs_strobe_i[3]` with code 3. With direction bit 0 it is an undriven input (code 0).
- R6: When expanded with `cs_en_i[2]`=1 and direction bit 1, pin 2 drives `cs_strobe_i[2]` with code 3. Otherwise it is a port pin.
- R7: When `dram_ctl_i` is 1, pin 1 drives `sdclk_i` with code 5 and output enable 1 in every mode and for either direction bit.
- R8: When expanded with `dram_ctl_i`=0, `cs_en_i[1]`=1 and direction bit 1, pin 1 drives `cs_strobe_i[1]` (code 3) if `area5_dram_i`=0. If `area5_dram_i`=1 it drives `ras_strobe_i[1]` (code 4).
- R9: When expanded with `cs_en_i[0]`=1 and direction bit 1, pin 0 drives `we_i` (code 6) if `sdram_contig_i`=1. Otherwise it drives `ras_strobe_i[0]` (code 4) if `area4_dram_i`=1, and otherwise `cs_strobe_i[0]` (code 3). With direction bit 0 it is a port pin.
- R10: With `single_chip_i`=1 and `exp_en_i`=0, every pin is a port pin (code 0) except pin 1 under R7. With `exp_en_i`=1 the expanded rules apply.
- R11: With its chip-select enable bit at 0, pins 0 to 2 are port pins in every mode except as R7 states. Pin 3 is also a port pin in that case unless R4 claims it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address: 0 direction, 1 data, 2 pin read |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| single_chip_i | input | 1 | 1 = single-chip operating mode |
| exp_en_i | input | 1 | Expansion flag, which enables bus functions in single-chip mode |
| cs_en_i | input | 4 | Chip-select enable per pin |
| oe_en_i | input | 1 | Output-enable strobe enable |
| oe_sel_i | input | 1 | Output-enable strobe placed on pin 3 |
| area4_dram_i | input | 1 | Area 4 is DRAM space |
| area5_dram_i | input | 1 | Area 5 is DRAM space |
| sdram_contig_i | input | 1 | Areas 2 to 5 are contiguous synchronous DRAM |
| dram_ctl_i | input | 1 | DRAM-control pin level |
| oe_strobe_i | input | 1 | Output-enable strobe value |
| cke_strobe_i | input | 1 | Clock-enable strobe value |
| cs_strobe_i | input | 4 | Chip-select values; bit n goes to pin n |
| ras_strobe_i | input | 2 | Row strobes; bit 0 for area 4, bit 1 for area 5 |
| sdclk_i | input | 1 | SDRAM clock |
| we_i | input | 1 | Write-enable strobe value |
| pin_in_i | input | 4 | External pin levels |
| pin_out_o | output | 4 | Pin drive values |
| pin_oe_o | output | 4 | Pin output enables |
| pin_func_o | output | 12 | 3-bit function code per pin, pin n at bits 3n+2:3n |

## Verification
The pin path has no registers, so a wrong priority decision shows up as a wrong function code and drive source on the pin, in the same cycle as the configuration change. A direction or data register that held a wrong value shows one clock edge after the write. It appears on `pin_oe_o` and `pin_out_o` of port pins, and on the address 1 and 2 reads. Chip-select and row-strobe selection depend on the direction bit, so a wrongly latched direction bit also moves pins between a bus function and port input.

// File: rtl/portx_pkg.sv
package portx_pkg;

  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_PORT  = 3'd0,
    FN_OE    = 3'd1,
    FN_CKE   = 3'd2,
    FN_CS    = 3'd3,
    FN_RAS   = 3'd4,
    FN_SDCLK = 3'd5,
    FN_WE    = 3'd6
  } pin_fn_e;

  typedef struct packed {
    logic expanded;
    logic oe_claim;
    logic contig;
    logic area4_dram;
    logic area5_dram;
    logic dram_ctl;
  } mux_cfg_t;

  typedef struct packed {
    logic       oe;
    logic       cke;
    logic [3:0] cs;
    logic [1:0] ras;
    logic       sdclk;
    logic       we;
  } strobe_t;

  // Layered priority: the DRAM-control pin first, then the bus functions when expanded, else port.
  function automatic pin_fn_e pick_fn(int idx, mux_cfg_t c, logic cs_on, logic dir);
    pin_fn_e f;
    f = FN_PORT;
    if (idx == 1 && c.dram_ctl) begin
      f = FN_SDCLK;
    end else if (c.expanded) begin
      case (idx)
        3: begin
          if (c.oe_claim) f = c.contig ? FN_CKE : FN_OE;
          else if (cs_on && dir) f = FN_CS;
        end
        2: if (cs_on && dir) f = FN_CS;
        1: if (cs_on && dir) f = c.area5_dram ? FN_RAS : FN_CS;
        0: if (cs_on && dir) f = c.contig ? FN_WE : (c.area4_dram ? FN_RAS : FN_CS);
        default: f = FN_PORT;
      endcase
    end
    return f;
  endfunction

endpackage

// File: rtl/portx_regs.sv
module portx_regs #(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  input  logic [NPINS-1:0] pin_in_i,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] dat_o,
  output logic [DW-1:0]    reg_rdata_o
);

  localparam logic [AW-1:0] ADDR_DIR = AW'(0);
  localparam logic [AW-1:0] ADDR_DAT = AW'(1);
  localparam logic [AW-1:0] ADDR_PIN = AW'(2);
  localparam int            PAD_W    = DW - NPINS;

  logic [NPINS-1:0] dir_q, dat_q, pin_view;
  logic             dir_wr, dat_wr;
  logic             unused_wdata_hi;

  assign dir_wr          = reg_wr_i && (reg_addr_i == ADDR_DIR);
  assign dat_wr          = reg_wr_i && (reg_addr_i == ADDR_DAT);
  assign unused_wdata_hi = ^reg_wdata_i[DW-1:NPINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      if (dir_wr) dir_q <= reg_wdata_i[NPINS-1:0];
      if (dat_wr) dat_q <= reg_wdata_i[NPINS-1:0];
    end
  end

  // Outputs reflect the data latch; inputs reflect the pin level.
  assign pin_view = (dir_q & dat_q) | (~dir_q & pin_in_i);

  always_comb begin
    case (reg_addr_i)
      ADDR_DAT: reg_rdata_o = {{PAD_W{1'b0}}, dat_q};
      ADDR_PIN: reg_rdata_o = {{PAD_W{1'b0}}, pin_view};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign dat_o = dat_q;

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr |=> dir_q == $past(reg_wdata_i[NPINS-1:0])); // R2
  AST_DAT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dat_wr |=> $stable(dat_q)); // R2
  AST_DIR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_DIR) |-> reg_rdata_o == '0); // R2

endmodule

// File: rtl/portx_pin_sel.sv
module portx_pin_sel
  import portx_pkg::*;
#(
  parameter int PIN_IDX = 0,
  parameter int NPINS   = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mux_cfg_t cfg_i,
  input  strobe_t  st_i,
  input  logic     cs_on_i,
  input  logic     dir_i,
  input  logic     dat_i,
  output pin_fn_e  fn_o,
  output logic     out_o,
  output logic     oe_o
);

  localparam int RAS_SEL = PIN_IDX % 2;
  localparam int CS_SEL  = PIN_IDX % NPINS;

  pin_fn_e fn_w;
  logic    drv_raw, oe_raw;
  logic    unused_st;

  assign unused_st = ^st_i;
  assign fn_w      = pick_fn(PIN_IDX, cfg_i, cs_on_i, dir_i);

  always_comb begin
    drv_raw = dat_i;
    oe_raw  = 1'b1;
    case (fn_w)
      FN_OE:    drv_raw = st_i.oe;
      FN_CKE:   drv_raw = st_i.cke;
      FN_CS:    drv_raw = st_i.cs[CS_SEL];
      FN_RAS:   drv_raw = st_i.ras[RAS_SEL];
      FN_SDCLK: drv_raw = st_i.sdclk;
      FN_WE:    drv_raw = st_i.we;
      default: begin
        drv_raw = dat_i;
        oe_raw  = dir_i;
      end
    endcase
  end

  assign fn_o  = fn_w;
  assign out_o = drv_raw;
  assign oe_o  = rst_ni ? oe_raw : 1'b0;

  AST_CS_NEEDS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_o == FN_CS || fn_o == FN_RAS || fn_o == FN_WE) |-> dir_i); // R5
  AST_PORT_OUT_IS_DAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_o == FN_PORT) |-> (oe_o == dir_i && out_o == dat_i)); // R3
  AST_BUS_FN_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_o != FN_PORT) |-> oe_o); // R4

  if (PIN_IDX == 1) begin : g_sdclk_chk
    AST_SDCLK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_i.dram_ctl |-> (fn_o == FN_SDCLK && out_o == st_i.sdclk)); // R7
  end

endmodule

// File: rtl/portx_pinmux.sv
module portx_pinmux
  import portx_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      reg_addr_i,
  input  logic               reg_wr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               single_chip_i,
  input  logic               exp_en_i,
  input  logic [NPINS-1:0]   cs_en_i,
  input  logic               oe_en_i,
  input  logic               oe_sel_i,
  input  logic               area4_dram_i,
  input  logic               area5_dram_i,
  input  logic               sdram_contig_i,
  input  logic               dram_ctl_i,
  input  logic               oe_strobe_i,
  input  logic               cke_strobe_i,
  input  logic [NPINS-1:0]   cs_strobe_i,
  input  logic [1:0]         ras_strobe_i,
  input  logic               sdclk_i,
  input  logic               we_i,
  input  logic [NPINS-1:0]   pin_in_i,
  output logic [NPINS-1:0]   pin_out_o,
  output logic [NPINS-1:0]   pin_oe_o,
  output logic [NPINS*FN_W-1:0] pin_func_o
);

  logic [NPINS-1:0] dir_w, dat_w;
  logic             expanded, oe_claim;
  mux_cfg_t         cfg;
  strobe_t          st;
  pin_fn_e          fn_w [NPINS];

  assign expanded = !single_chip_i || exp_en_i;
  assign oe_claim = oe_en_i && oe_sel_i;

  assign cfg = '{expanded:   expanded,
                 oe_claim:   oe_claim,
                 contig:     sdram_contig_i,
                 area4_dram: area4_dram_i,
                 area5_dram: area5_dram_i,
                 dram_ctl:   dram_ctl_i};

  assign st = '{oe: oe_strobe_i, cke: cke_strobe_i, cs: cs_strobe_i,
                ras: ras_strobe_i, sdclk: sdclk_i, we: we_i};

  portx_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .pin_in_i    (pin_in_i),
    .dir_o       (dir_w),
    .dat_o       (dat_w),
    .reg_rdata_o (reg_rdata_o)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    portx_pin_sel #(.PIN_IDX(i), .NPINS(NPINS)) sel_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cfg_i   (cfg),
      .st_i    (st),
      .cs_on_i (cs_en_i[i]),
      .dir_i   (dir_w[i]),
      .dat_i   (dat_w[i]),
      .fn_o    (fn_w[i]),
      .out_o   (pin_out_o[i]),
      .oe_o    (pin_oe_o[i])
    );
    assign pin_func_o[i*FN_W +: FN_W] = fn_w[i];
  end

  always_comb begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (pin_oe_o == '0); // R1
    end
  end

  AST_SINGLE_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!expanded && !dram_ctl_i) |-> pin_func_o == '0); // R10
  AST_OE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expanded && oe_claim) |-> pin_oe_o[NPINS-1]); // R4

endmodule

// File: tb/portx_pinmux_tb_top.sv
module portx_pinmux_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       single_chip, exp_en, oe_en, oe_sel, a4d, a5d, contig, dctl;
  logic [3:0] cs_en, cs_st, pin_in, pin_out, pin_oe;
  logic [1:0] ras_st;
  logic       oe_st, cke_st, sdclk, we;
  logic [11:0] pin_func;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  portx_pinmux dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .single_chip_i(single_chip),
    .exp_en_i(exp_en), .cs_en_i(cs_en), .oe_en_i(oe_en), .oe_sel_i(oe_sel),
    .area4_dram_i(a4d), .area5_dram_i(a5d), .sdram_contig_i(contig),
    .dram_ctl_i(dctl), .oe_strobe_i(oe_st), .cke_strobe_i(cke_st),
    .cs_strobe_i(cs_st), .ras_strobe_i(ras_st), .sdclk_i(sdclk), .we_i(we),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe),
    .pin_func_o(pin_func)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_pin(string req, int p, int fn, int oe, int out);
    chk(req, $sformatf("pin%0d func", p), int'(pin_func[p*3 +: 3]), fn);
    chk(req, $sformatf("pin%0d oe", p), int'(pin_oe[p]), oe);
    if (oe == 1) chk(req, $sformatf("pin%0d out", p), int'(pin_out[p]), out);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wreg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(string req, logic [1:0] a, int exp);
    addr = a; #1;
    chk(req, $sformatf("read addr %0d", a), int'(rdata), exp);
  endtask

  task automatic defaults();
    single_chip = 1'b1; exp_en = 1'b0; oe_en = 1'b0; oe_sel = 1'b0;
    a4d = 1'b0; a5d = 1'b0; contig = 1'b0; dctl = 1'b0; cs_en = '0;
    cs_st = 4'b1010; ras_st = 2'b01; oe_st = 1'b1; cke_st = 1'b0;
    sdclk = 1'b1; we = 1'b0; pin_in = '0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "oe in reset", int'(pin_oe), 0);
    repeat (2) @(negedge clk);
    chk("R1", "oe in reset late", int'(pin_oe), 0);
    rst_n = 1'b1;
    settle();
    chk("R1", "oe after reset", int'(pin_oe), 0);
    chk("R1", "func after reset", int'(pin_func), 0);
    rreg("R1", 2'd1, 0);
  endtask

  task automatic t_regs();
    wreg(2'd0, 8'hA5);
    settle();
    rreg("R2", 2'd0, 0);
    chk("R2", "dir via oe", int'(pin_oe), 4'b0101);
    wreg(2'd1, 8'hF3);
    rreg("R2", 2'd1, 8'h03);
  endtask

  task automatic t_port();
    wreg(2'd0, 8'h05);
    wreg(2'd1, 8'h03);
    pin_in = 4'b1010;
    settle();
    chk_pin("R3", 0, 0, 1, 1);
    chk_pin("R3", 2, 0, 1, 0);
    chk_pin("R3", 1, 0, 0, 0);
    rreg("R3", 2'd2, 8'h0B);
    pin_in = 4'b0000; #1;
    rreg("R3", 2'd2, 8'h01);
  endtask

  task automatic t_oe();
    defaults(); single_chip = 1'b0;
    wreg(2'd0, 8'h00);
    oe_en = 1'b1; oe_sel = 1'b1; oe_st = 1'b1;
    settle();
    chk_pin("R4", 3, 1, 1, 1);
    oe_st = 1'b0; #1;
    chk_pin("R4", 3, 1, 1, 0);
    contig = 1'b1; cke_st = 1'b1; #1;
    chk_pin("R4", 3, 2, 1, 1);
    oe_sel = 1'b0; #1;
    chk_pin("R4", 3, 0, 0, 0);
  endtask

  task automatic t_cs7();
    defaults(); single_chip = 1'b0; cs_en = 4'b1000;
    oe_en = 1'b1; oe_sel = 1'b0;
    wreg(2'd0, 8'h08);
    settle();
    chk_pin("R5", 3, 3, 1, 1);
    cs_st[3] = 1'b0; #1;
    chk_pin("R5", 3, 3, 1, 0);
    wreg(2'd0, 8'h00);
    settle();
    chk_pin("R5", 3, 0, 0, 0);
  endtask

  task automatic t_cs6();
    defaults(); single_chip = 1'b0; cs_en = 4'b0100; cs_st = 4'b0100;
    wreg(2'd0, 8'h04);
    settle();
    chk_pin("R6", 2, 3, 1, 1);
    cs_en = 4'b0000; #1;
    chk_pin("R6", 2, 0, 1, 0);
  endtask

  task automatic t_sdclk();
    defaults(); dctl = 1'b1; sdclk = 1'b1;
    wreg(2'd0, 8'h00);
    settle();
    chk_pin("R7", 1, 5, 1, 1);
    sdclk = 1'b0; #1;
    chk_pin("R7", 1, 5, 1, 0);
    single_chip = 1'b0; cs_en = 4'b0010; a5d = 1'b1;
    wreg(2'd0, 8'h02);
    settle();
    chk_pin("R7", 1, 5, 1, 0);
  endtask

  task automatic t_pin1();
    defaults(); single_chip = 1'b0; cs_en = 4'b0010;
    cs_st = 4'b0010; ras_st = 2'b00;
    wreg(2'd0, 8'h02);
    settle();
    chk_pin("R8", 1, 3, 1, 1);
    a5d = 1'b1; ras_st = 2'b10; cs_st = 4'b0000; #1;
    chk_pin("R8", 1, 4, 1, 1);
  endtask

  task automatic t_pin0();
    defaults(); single_chip = 1'b0; cs_en = 4'b0001;
    cs_st = 4'b0001; ras_st = 2'b00; we = 1'b0;
    wreg(2'd0, 8'h01);
    settle();
    chk_pin("R9", 0, 3, 1, 1);
    a4d = 1'b1; ras_st = 2'b01; cs_st = 4'b0000; #1;
    chk_pin("R9", 0, 4, 1, 1);
    contig = 1'b1; we = 1'b1; ras_st = 2'b00; #1;
    chk_pin("R9", 0, 6, 1, 1);
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h00);
    settle();
    chk_pin("R9", 0, 0, 0, 0);
  endtask

  task automatic t_single();
    defaults(); cs_en = 4'b1111; oe_en = 1'b1; oe_sel = 1'b1; a4d = 1'b1;
    wreg(2'd1, 8'h0F);
    wreg(2'd0, 8'h0F);
    settle();
    chk("R10", "all port func", int'(pin_func), 0);
    chk("R10", "port drive", int'(pin_out & pin_oe), 4'hF);
    exp_en = 1'b1; #1;
    chk_pin("R10", 3, 1, 1, 1);
    chk_pin("R10", 0, 4, 1, 1);
  endtask

  task automatic t_cs_off();
    defaults(); single_chip = 1'b0; cs_en = 4'b0000;
    a4d = 1'b1; a5d = 1'b1; contig = 1'b1;
    wreg(2'd1, 8'h06);
    wreg(2'd0, 8'h0F);
    settle();
    chk_pin("R11", 0, 0, 1, 0);
    chk_pin("R11", 1, 0, 1, 1);
    chk_pin("R11", 2, 0, 1, 1);
    chk_pin("R11", 3, 0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    defaults();
    t_reset();
    t_regs();
    t_port();
    t_oe();
    t_cs7();
    t_cs6();
    t_sdclk();
    t_pin1();
    t_pin0();
    t_single();
    t_cs_off();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule